// File: doc/BRIEF.md
# Flag Input and Q Output Unit

This unit gives a small processor core one software-controlled output bit and a group of external condition pins that branch instructions can test. The sequencer sends one strobe to raise the output, another to lower it, and one to say that a conditional branch is in its execute cycle. With the execute strobe it sends a selector that names the flag pin to test and the sense of the test.

The flag pins come from outside the clock domain, so each one passes through its own chain of flip-flops before any branch uses it. The branch decision is registered. It appears as a one-cycle pulse in the cycle after the execute strobe, and the sequencer uses that pulse to load the branch target. Computing the target address and fetching instructions are handled elsewhere.

Top module: `fq_io_unit`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `q_o` and `br_taken_o` are both 0.
- R2: A cycle with `set_q_i`=1 and `clr_q_i`=0 makes `q_o` 1 from the next clock edge.
- R3: A cycle with `clr_q_i`=1 and `set_q_i`=0 makes `q_o` 0 from the next clock edge.
- R4: A cycle with both `set_q_i` and `clr_q_i` high leaves `q_o` unchanged.
- R5: With neither Q strobe high, `q_o` keeps its value, and branch activity does not change it.
- R6: `br_taken_o` can be 1 only in the cycle right after a cycle with `br_exec_i`=1. It lasts one cycle per strobe.
- R7: Selector encoding: `br_sel_i[1:0]` picks flag pin 0..3. With `br_sel_i[2]`=0 the branch is taken when the synchronized selected flag is 1.
- R8: With `br_sel_i[2]`=1 the branch is taken when the synchronized selected flag is 0.
- R9: A pin change becomes visible to a branch only after two clock edges. An execute strobe sampled on the second edge after the change still sees the old level. A strobe on the third edge sees the new level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| set_q_i | input | 1 | Strobe that raises the output bit |
| clr_q_i | input | 1 | Strobe that lowers the output bit |
| br_exec_i | input | 1 | Conditional branch is in its execute cycle |
| br_sel_i | input | 3 | [1:0] flag index, [2] test sense (1 = branch on flag low) |
| flag_pin_i | input | 4 | Asynchronous external flag pins, active high by default |
| q_o | output | 1 | Latched output bit |
| br_taken_o | output | 1 | Registered branch decision pulse |

## Verification
The assertions assume that `br_sel_i` is stable and valid in every cycle where `br_exec_i` is high. They also assume that `br_exec_i` and the Q strobes are synchronous to `clk`. The flag pins are the only inputs that may change at any time, and the stimulus changes them only between clock edges, on the falling edge. Every other input is also driven on the falling edge. Outside the latency test, a flag change is given at least three edges to settle before any branch tests it.

// File: rtl/fq_pkg.sv
package fq_pkg;
   // Sense of a conditional-branch test
   typedef enum logic {
      FQ_ON_HIGH = 1'b0,
      FQ_ON_LOW  = 1'b1
   } fq_sense_e;

   localparam int unsigned FQ_MIN_SYNC = 2;

   function automatic logic fq_decide(input logic level, input fq_sense_e sense);
      return (sense == FQ_ON_LOW) ? ~level : level;
   endfunction
endpackage

// File: rtl/fq_sync.sv
module fq_sync #(
   parameter int unsigned WIDTH  = 4,
   parameter int unsigned STAGES = 2,
   parameter logic        IDLE   = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);
   import fq_pkg::*;

   generate
      if (STAGES < FQ_MIN_SYNC) begin : g_bad_stages
         $error("fq_sync: STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("fq_sync: WIDTH must be at least 1");
      end
   endgenerate

   logic [STAGES-1:0][WIDTH-1:0] chain_q;

   always_ff @(posedge clk) begin
      if (!rst_n) chain_q[0] <= {WIDTH{IDLE}};
      else        chain_q[0] <= async_i;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
         if (!rst_n) chain_q[s] <= {WIDTH{IDLE}};
         else        chain_q[s] <= chain_q[s-1];
      end
   end

   assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/fq_qbit.sv
module fq_qbit (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);
   logic q_r;

   always_ff @(posedge clk) begin
      if (!rst_n)             q_r <= 1'b0;
      else if (set_i && !clr_i) q_r <= 1'b1;
      else if (clr_i && !set_i) q_r <= 1'b0;
   end

   assign q_o = q_r;

   AST_Q_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i && !clr_i) |=> q_o); // R2
   AST_Q_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !set_i) |=> !q_o); // R3
   AST_Q_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i == clr_i) |=> $stable(q_o)); // R4 R5
endmodule

// File: rtl/fq_cond_eval.sv
module fq_cond_eval #(
   parameter int unsigned NUM_FLAGS = 4,
   parameter int unsigned IDX_W     = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 exec_i,
   input  logic [IDX_W-1:0]     idx_i,
   input  logic                 sense_i,
   input  logic [NUM_FLAGS-1:0] level_i,
   output logic                 taken_o
);
   import fq_pkg::*;

   logic picked;
   logic taken_r;

   generate
      if ((1 << IDX_W) == NUM_FLAGS) begin : g_full_index
         assign picked = level_i[idx_i];
      end else begin : g_partial_index
         // Index values past the last flag read as low
         always_comb begin
            picked = 1'b0;
            for (int i = 0; i < NUM_FLAGS; i++)
               if (idx_i == IDX_W'(i)) picked = level_i[i];
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) taken_r <= 1'b0;
      else        taken_r <= exec_i && fq_decide(picked, fq_sense_e'(sense_i));
   end

   assign taken_o = taken_r;

   AST_BR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      !exec_i |=> !taken_o); // R6
endmodule

// File: rtl/fq_io_unit.sv
module fq_io_unit #(
   parameter int unsigned NUM_FLAGS       = 4,
   parameter int unsigned SYNC_STAGES     = 2,
   parameter bit          FLAG_ACTIVE_LOW = 1'b0,
   localparam int unsigned IDX_W          = (NUM_FLAGS > 1) ? $clog2(NUM_FLAGS) : 1,
   localparam int unsigned SEL_W          = IDX_W + 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 set_q_i,
   input  logic                 clr_q_i,
   input  logic                 br_exec_i,
   input  logic [SEL_W-1:0]     br_sel_i,
   input  logic [NUM_FLAGS-1:0] flag_pin_i,
   output logic                 q_o,
   output logic                 br_taken_o
);
   generate
      if (NUM_FLAGS < 2) begin : g_bad_flags
         $error("fq_io_unit: NUM_FLAGS must be at least 2");
      end
   endgenerate

   logic [NUM_FLAGS-1:0] sync_lvl;
   logic [NUM_FLAGS-1:0] asserted;

   fq_sync #(
      .WIDTH  (NUM_FLAGS),
      .STAGES (SYNC_STAGES),
      .IDLE   (FLAG_ACTIVE_LOW)
   ) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (flag_pin_i),
      .sync_o  (sync_lvl)
   );

   generate
      if (FLAG_ACTIVE_LOW) begin : g_inv
         assign asserted = ~sync_lvl;
      end else begin : g_pass
         assign asserted = sync_lvl;
      end
   endgenerate

   fq_qbit u_qbit (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (set_q_i),
      .clr_i (clr_q_i),
      .q_o   (q_o)
   );

   fq_cond_eval #(
      .NUM_FLAGS (NUM_FLAGS),
      .IDX_W     (IDX_W)
   ) u_eval (
      .clk     (clk),
      .rst_n   (rst_n),
      .exec_i  (br_exec_i),
      .idx_i   (br_sel_i[IDX_W-1:0]),
      .sense_i (br_sel_i[SEL_W-1]),
      .level_i (asserted),
      .taken_o (br_taken_o)
   );

   AST_BR_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (br_exec_i && !br_sel_i[SEL_W-1]) |=> (br_taken_o == $past(asserted[br_sel_i[IDX_W-1:0]]))); // R7
   AST_BR_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (br_exec_i && br_sel_i[SEL_W-1]) |=> (br_taken_o == !$past(asserted[br_sel_i[IDX_W-1:0]]))); // R8
endmodule

// File: tb/fq_io_unit_tb.sv
module fq_io_unit_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       set_q_i = 1'b0, clr_q_i = 1'b0, br_exec_i = 1'b0;
   logic [2:0] br_sel_i = 3'd0;
   logic [3:0] flag_pin_i = 4'd0;
   logic       q_o, br_taken_o;

   int errors = 0;
   int checks = 0;

   always #5 clk = ~clk;

   fq_io_unit u_dut (
      .clk (clk), .rst_n (rst_n), .set_q_i (set_q_i), .clr_q_i (clr_q_i),
      .br_exec_i (br_exec_i), .br_sel_i (br_sel_i), .flag_pin_i (flag_pin_i),
      .q_o (q_o), .br_taken_o (br_taken_o)
   );

   // {pins[3:0], sel[2:0], expected taken}
   localparam logic [7:0] VEC [16] = '{
      {4'b0001, 3'd0, 1'b1}, {4'b1110, 3'd0, 1'b0},
      {4'b0010, 3'd1, 1'b1}, {4'b1101, 3'd1, 1'b0},
      {4'b0100, 3'd2, 1'b1}, {4'b1011, 3'd2, 1'b0},
      {4'b1000, 3'd3, 1'b1}, {4'b0111, 3'd3, 1'b0},
      {4'b1110, 3'd4, 1'b1}, {4'b0001, 3'd4, 1'b0},
      {4'b1101, 3'd5, 1'b1}, {4'b0010, 3'd5, 1'b0},
      {4'b1011, 3'd6, 1'b1}, {4'b0100, 3'd6, 1'b0},
      {4'b0111, 3'd7, 1'b1}, {4'b1000, 3'd7, 1'b0}
   };

   task automatic check(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%b expected=%b", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      #1_000_000;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      tick(3);
      check("R1 reset q", q_o, 1'b0);
      check("R1 reset taken", br_taken_o, 1'b0);
      rst_n = 1'b1;
      tick(1);
      check("R1 after reset q", q_o, 1'b0);
      check("R1 after reset taken", br_taken_o, 1'b0);

      // R7 R8 R6: table walk
      for (int i = 0; i < 16; i++) begin
         flag_pin_i = VEC[i][7:4];
         tick(3);
         br_sel_i = VEC[i][3:1];
         br_exec_i = 1'b1;
         tick(1);
         br_exec_i = 1'b0;
         check(VEC[i][3] ? "R8 branch on low" : "R7 branch on high", br_taken_o, VEC[i][0]);
         tick(1);
         check("R6 pulse ends", br_taken_o, 1'b0);
      end

      // R6: no strobe, true condition, no pulse
      flag_pin_i = 4'b1111; br_sel_i = 3'd0;
      tick(4);
      check("R6 no exec", br_taken_o, 1'b0);

      // R2 R3 R4 R5
      set_q_i = 1'b1; tick(1); set_q_i = 1'b0;
      check("R2 set", q_o, 1'b1);
      tick(2);
      check("R5 hold high", q_o, 1'b1);
      br_exec_i = 1'b1; br_sel_i = 3'd4; tick(1); br_exec_i = 1'b0;
      check("R5 branch leaves q", q_o, 1'b1);
      set_q_i = 1'b1; clr_q_i = 1'b1; tick(1); set_q_i = 1'b0; clr_q_i = 1'b0;
      check("R4 both high keeps 1", q_o, 1'b1);
      clr_q_i = 1'b1; tick(1); clr_q_i = 1'b0;
      check("R3 clear", q_o, 1'b0);
      set_q_i = 1'b1; clr_q_i = 1'b1; tick(1); set_q_i = 1'b0; clr_q_i = 1'b0;
      check("R4 both high keeps 0", q_o, 1'b0);
      tick(2);
      check("R5 hold low", q_o, 1'b0);

      // R9: synchronizer latency on flag 2
      flag_pin_i = 4'b0000; tick(4);
      flag_pin_i = 4'b0100; br_sel_i = 3'd2;
      tick(1);
      br_exec_i = 1'b1;
      tick(1);
      check("R9 second edge old level", br_taken_o, 1'b0);
      tick(1);
      br_exec_i = 1'b0;
      check("R9 third edge new level", br_taken_o, 1'b1);

      // R1: reset in mid-use
      set_q_i = 1'b1; tick(1); set_q_i = 1'b0;
      rst_n = 1'b0; tick(1);
      check("R1 reset clears q", q_o, 1'b0);
      rst_n = 1'b1;

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule